// File: doc/BRIEF.md
# Three-Mode Local Interrupt Timer

This block is a per-core interrupt timer. It runs in one of three modes. In one-shot mode and periodic mode, a current count decrements from a programmed start value at a rate derived from the bus clock. In deadline mode, the block compares a free-running 64-bit timestamp input against a programmed 64-bit deadline. Each expiry produces a single-cycle interrupt request pulse, and the programmed vector travels with that pulse.

Software reaches the block through a flat register port. Writes take effect on a clock edge, and reads are combinational on the address. Mode and divider changes apply while the timer runs. Moving between one-shot and periodic mode leaves the countdown running. Moving into or out of deadline mode disarms everything. A divider change alters the decrement rate and leaves the count value untouched.

Top module: `irq_timer`

## Requirements
- R1: After reset every register reads zero, the mode is one-shot and no interrupt pulse is raised. The register addresses are: 0 entry, 1 start count, 2 current count (read-only), 3 divider, 4 deadline low word, 5 deadline high word.
- R2: In one-shot mode, writing a nonzero start value N with divisor D raises one pulse N*D edges after the write edge. The count then stays at zero.
- R3: In periodic mode, after each expiry the count reloads from the start value. Pulses repeat every N*D edges.
- R4: The divider code is formed from wdata bits {3,1,0}. Codes 0 to 6 divide by 2 to 128 in powers of two, and code 7 divides by 1. The divider register reads back those same three bits.
- R5: A divider write leaves the current count unchanged on that edge. The new rate applies from a freshly restarted prescaler period.
- R6: A mode write between one-shot and periodic keeps the count decrementing. The mode is sampled only when the count reaches zero: periodic reloads, one-shot stops.
- R7: A mode write that enters or leaves deadline mode (mode code 2) clears the start count, the current count and the deadline to zero. No pulse follows from the old state.
- R8: In deadline mode, one pulse is raised one edge after the timestamp is at or above a nonzero deadline. The deadline then reads zero and does not fire again.
- R9: A deadline of zero never raises a pulse, whatever the timestamp value.
- R10: A start value of zero disarms the countdown. Writes to the start value are ignored in deadline mode.
- R11: In periodic mode, a start value below MIN_PERIOD ticks is raised to MIN_PERIOD. This happens when the value is loaded and at each reload, including the first reload after a switch from one-shot mode.
- R12: The entry register holds the vector in bits [7:0], the mask in bit 16 and the mode in bits [18:17]. The pulse carries the vector. The mask suppresses the pulse but not the counting. Mode code 3 behaves as one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ts_i | input | TS_W | Free-running timestamp |
| irq_o | output | 1 | Single-cycle interrupt pulse |
| irq_vec_o | output | VEC_W | Vector carried with the pulse |

## Verification
The countdown is driven with several start values under divisors 1, 2 and 16, so that errors in the latency scaling and in the divider decode show up separately. Periodic runs are checked across several intervals. Start values below the minimum separate the clamped periodic path from the unclamped one-shot path. Mode writes issued mid-count distinguish a running switch from a disarming crossing. Divider writes issued mid-count are checked against both the count read back and the later expiry time. Deadline stimuli place the timestamp below, at and far above the deadline, and also use a zero deadline and a stale deadline left over from before a mode crossing.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
    localparam logic [2:0] A_ENTRY = 3'd0;
    localparam logic [2:0] A_INIT  = 3'd1;
    localparam logic [2:0] A_CUR   = 3'd2;
    localparam logic [2:0] A_DIV   = 3'd3;
    localparam logic [2:0] A_DL_LO = 3'd4;
    localparam logic [2:0] A_DL_HI = 3'd5;

    localparam logic [1:0] M_ONESHOT  = 2'd0;
    localparam logic [1:0] M_PERIODIC = 2'd1;
    localparam logic [1:0] M_DEADLINE = 2'd2;

    localparam int MASK_BIT = 16;
    localparam int MODE_LSB = 17;
    localparam int PRESC_W  = 7;

    // terminal prescaler value for a divider code
    function automatic logic [PRESC_W-1:0] div_last(input logic [2:0] code);
        logic [7:0] v;
        if (code == 3'b111) begin
            v = 8'd0;
        end else begin
            v = (8'd2 << code) - 8'd1;
        end
        return v[PRESC_W-1:0];
    endfunction
endpackage

// File: rtl/irq_timer_presc.sv
module irq_timer_presc
    import irq_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] code,
    output logic       tick
);
    logic [PRESC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == div_last(code)) && !restart;
        cnt_d = cnt_q + 1'b1;
        if (restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/irq_timer_dlcmp.sv
module irq_timer_dlcmp #(
    parameter int TS_W = 64
) (
    input  logic            enable,
    input  logic [TS_W-1:0] ts,
    input  logic [TS_W-1:0] deadline,
    output logic            hit
);
    always_comb begin
        hit = enable && (deadline != '0) && (ts >= deadline);
    end
endmodule

// File: rtl/irq_timer.sv
module irq_timer
    import irq_timer_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int VEC_W      = 8,
    parameter int TS_W       = 64,
    parameter int MIN_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [TS_W-1:0]  ts_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] irq_vec_o
);
    localparam int DATA_W  = 32;
    localparam int DL_HI_W = TS_W - DATA_W;
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PERIOD);

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             mask;
        logic [1:0]       mode;
        logic [CNT_W-1:0] init;
        logic [CNT_W-1:0] cur;
        logic [2:0]       dcode;
        logic [TS_W-1:0]  dl;
        logic             irq;
    } state_t;

    state_t s_d, s_q;

    logic tick, dl_hit, restart, dl_mode;
    logic wr_entry, wr_init, wr_div, wr_dl_lo, wr_dl_hi;
    logic [1:0] new_mode;
    logic fire;

    // signals exposed to the bound checker
    logic [1:0]       mode_cur;
    logic             mask_cur;
    logic [CNT_W-1:0] init_cnt, cur_cnt;
    logic [TS_W-1:0]  dl_val;

    function automatic logic [CNT_W-1:0] clamp_period(input logic [CNT_W-1:0] v);
        if (v != '0 && v < MIN_C) return MIN_C;
        return v;
    endfunction

    always_comb begin
        dl_mode  = (s_q.mode == M_DEADLINE);
        wr_entry = reg_we && (reg_addr == A_ENTRY);
        wr_init  = reg_we && (reg_addr == A_INIT);
        wr_div   = reg_we && (reg_addr == A_DIV);
        wr_dl_lo = reg_we && (reg_addr == A_DL_LO);
        wr_dl_hi = reg_we && (reg_addr == A_DL_HI);
        new_mode = reg_wdata[MODE_LSB +: 2];
        restart  = wr_div || (wr_init && !dl_mode);
    end

    irq_timer_presc u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .code    (s_q.dcode),
        .tick    (tick)
    );

    irq_timer_dlcmp #(.TS_W(TS_W)) u_dlcmp (
        .enable   (dl_mode),
        .ts       (ts_i),
        .deadline (s_q.dl),
        .hit      (dl_hit)
    );

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;

        // countdown path
        if (!dl_mode && s_q.cur != '0 && tick) begin
            if (s_q.cur == CNT_W'(1)) begin
                fire  = 1'b1;
                s_d.cur = (s_q.mode == M_PERIODIC) ? clamp_period(s_q.init) : '0;
            end else begin
                s_d.cur = s_q.cur - 1'b1;
            end
        end

        // deadline path
        if (dl_hit) begin
            fire   = 1'b1;
            s_d.dl = '0;
        end

        // register writes
        if (wr_init && !dl_mode) begin
            s_d.init = reg_wdata[CNT_W-1:0];
            s_d.cur  = (s_q.mode == M_PERIODIC) ? clamp_period(reg_wdata[CNT_W-1:0])
                                                : reg_wdata[CNT_W-1:0];
        end
        if (wr_div) begin
            s_d.dcode = {reg_wdata[3], reg_wdata[1], reg_wdata[0]};
        end
        if (wr_dl_lo) begin
            s_d.dl[DATA_W-1:0] = reg_wdata;
        end
        if (wr_dl_hi) begin
            s_d.dl[TS_W-1:DATA_W] = reg_wdata[DL_HI_W-1:0];
        end
        if (wr_entry) begin
            s_d.vec  = reg_wdata[VEC_W-1:0];
            s_d.mask = reg_wdata[MASK_BIT];
            s_d.mode = new_mode;
            if ((new_mode == M_DEADLINE) != dl_mode) begin
                s_d.init = '0;
                s_d.cur  = '0;
                s_d.dl   = '0;
            end
        end

        s_d.irq = fire && !s_q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ENTRY: begin
                reg_rdata[VEC_W-1:0]       = s_q.vec;
                reg_rdata[MASK_BIT]        = s_q.mask;
                reg_rdata[MODE_LSB +: 2]   = s_q.mode;
            end
            A_INIT:  reg_rdata[CNT_W-1:0] = s_q.init;
            A_CUR:   reg_rdata[CNT_W-1:0] = s_q.cur;
            A_DIV: begin
                reg_rdata[3] = s_q.dcode[2];
                reg_rdata[1] = s_q.dcode[1];
                reg_rdata[0] = s_q.dcode[0];
            end
            A_DL_LO: reg_rdata = s_q.dl[DATA_W-1:0];
            A_DL_HI: reg_rdata[DL_HI_W-1:0] = s_q.dl[TS_W-1:DATA_W];
            default: reg_rdata = '0;
        endcase
    end

    always_comb begin
        irq_o     = s_q.irq;
        irq_vec_o = s_q.vec;
        mode_cur  = s_q.mode;
        mask_cur  = s_q.mask;
        init_cnt  = s_q.init;
        cur_cnt   = s_q.cur;
        dl_val    = s_q.dl;
    end
endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk #(
    parameter int CNT_W = 32,
    parameter int TS_W  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             irq,
    input logic [1:0]       mode,
    input logic             mask,
    input logic [CNT_W-1:0] init,
    input logic [CNT_W-1:0] cur,
    input logic [TS_W-1:0]  dl
);
    logic entry_wr, cross_wr;
    always_comb begin
        entry_wr = reg_we && reg_addr == 3'd0;
        cross_wr = entry_wr && ((reg_wdata[18:17] == 2'd2) != (mode == 2'd2));
    end

    a_r7_cross_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cross_wr |=> (init == '0 && cur == '0 && dl == '0));

    a_r6_switch_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_wr && !cross_wr && mode != 2'd2 && cur > CNT_W'(1)) |=> cur != '0);

    a_r5_div_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd3) |=> cur == $past(cur));

    a_r9_zero_dl_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && dl == '0) |=> !irq);

    a_r12_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(mask));

    a_r2_oneshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && cur == '0 && !(reg_we && (reg_addr == 3'd1 || reg_addr == 3'd0)))
        |=> cur == '0);

    a_r10_dl_init_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && reg_we && reg_addr == 3'd1) |=> init == $past(init));
endmodule

bind irq_timer irq_timer_chk #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq_o),
    .mode      (mode_cur),
    .mask      (mask_cur),
    .init      (init_cnt),
    .cur       (cur_cnt),
    .dl        (dl_val)
);

// File: tb/irq_timer_bench.sv
module irq_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [63:0] ts = 64'd0;
    logic        irq;
    logic [7:0]  irq_vec;

    int checks = 0;
    int fails  = 0;

    irq_timer u_irq_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ts_i      (ts),
        .irq_o     (irq),
        .irq_vec_o (irq_vec)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #2;
        v = reg_rdata;
    endtask

    task automatic wait_irq(input int maxc, output int cnt, output logic [7:0] vec);
        cnt = 0; vec = 8'd0;
        for (int i = 1; i <= maxc; i++) begin
            @(posedge clk); #1;
            if (irq) begin cnt = i; vec = irq_vec; break; end
        end
    endtask

    task automatic count_irqs(input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (irq) k++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check(v == 0, "R1 reset register", v, 0);
        end
        check(irq == 1'b0, "R1 reset irq", irq, 0);
    endtask

    task automatic t_oneshot();
        int c; logic [7:0] vv; logic [31:0] v;
        wr(3'd3, 32'hB);
        wr(3'd0, 32'h0000_005A);
        wr(3'd1, 32'd5);
        wait_irq(50, c, vv);
        check(c == 5, "R2 one-shot latency", c, 5);
        check(vv == 8'h5A, "R12 vector on pulse", vv, 8'h5A);
        count_irqs(20, c);
        check(c == 0, "R2 one-shot no repeat", c, 0);
        rd(3'd2, v);
        check(v == 0, "R2 count stays zero", v, 0);
    endtask

    task automatic t_div();
        int c; logic [7:0] vv; logic [31:0] v;
        wr(3'd3, 32'h3);
        wr(3'd1, 32'd2);
        wait_irq(100, c, vv);
        check(c == 32, "R4 divide by 16", c, 32);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'd3);
        wait_irq(100, c, vv);
        check(c == 6, "R4 divide by 2", c, 6);
        wr(3'd3, 32'hFFFF_FFFB);
        rd(3'd3, v);
        check(v == 32'hB, "R4 divider readback", v, 32'hB);
    endtask

    task automatic t_periodic();
        int c; logic [7:0] vv; logic [31:0] v;
        wr(3'd0, 32'h0002_0011);
        wr(3'd1, 32'd6);
        for (int p = 0; p < 3; p++) begin
            wait_irq(50, c, vv);
            check(c == 6, "R3 periodic interval", c, 6);
        end
        wr(3'd0, 32'h0000_0011);
        wait_irq(50, c, vv);
        check(c == 5, "R6 switch to one-shot finishes period", c, 5);
        count_irqs(30, c);
        check(c == 0, "R6 one-shot stops at zero", c, 0);
        rd(3'd2, v);
        check(v == 0, "R6 count zero after stop", v, 0);
    endtask

    task automatic t_switch();
        int c; logic [7:0] vv; logic [31:0] v;
        wr(3'd0, 32'h0000_0022);
        wr(3'd1, 32'd6);
        repeat (2) begin @(posedge clk); #1; end
        wr(3'd0, 32'h0002_0022);
        wait_irq(50, c, vv);
        check(c == 3, "R6 count continues across switch", c, 3);
        wait_irq(50, c, vv);
        check(c == 6, "R6 periodic reload after switch", c, 6);
        wr(3'd1, 32'd0);
        count_irqs(30, c);
        check(c == 0, "R10 zero start disarms", c, 0);
        rd(3'd2, v);
        check(v == 0, "R10 count zero", v, 0);
    endtask

    task automatic t_clamp();
        int c; logic [7:0] vv;
        wr(3'd1, 32'd2);
        wait_irq(50, c, vv);
        check(c == 4, "R11 clamped first period", c, 4);
        wait_irq(50, c, vv);
        check(c == 4, "R11 clamped reload", c, 4);
        wr(3'd0, 32'h0000_0022);
        wr(3'd1, 32'd2);
        wait_irq(50, c, vv);
        check(c == 2, "R11 no clamp in one-shot", c, 2);
        wr(3'd1, 32'd2);
        wr(3'd0, 32'h0002_0022);
        wait_irq(50, c, vv);
        check(c == 1, "R11 expiry after switch", c, 1);
        wait_irq(50, c, vv);
        check(c == 4, "R11 clamp on reload after switch", c, 4);
        wr(3'd1, 32'd0);
    endtask

    task automatic t_divchange();
        int c; logic [7:0] vv; logic [31:0] v;
        wr(3'd0, 32'h0000_0033);
        wr(3'd3, 32'hB);
        wr(3'd1, 32'd10);
        repeat (3) begin @(posedge clk); #1; end
        rd(3'd2, v);
        check(v == 7, "R5 count before divider write", v, 7);
        wr(3'd3, 32'h0);
        rd(3'd2, v);
        check(v == 7, "R5 count unchanged by divider write", v, 7);
        wait_irq(100, c, vv);
        check(c == 14, "R5 new rate after divider write", c, 14);
        wr(3'd3, 32'hB);
    endtask

    task automatic t_mask_rsvd();
        int c; logic [7:0] vv; logic [31:0] v;
        wr(3'd0, 32'h0001_0044);
        wr(3'd1, 32'd3);
        count_irqs(10, c);
        check(c == 0, "R12 mask suppresses pulse", c, 0);
        rd(3'd2, v);
        check(v == 0, "R12 masked count ran out", v, 0);
        wr(3'd0, 32'h0006_0044);
        wr(3'd1, 32'd3);
        wait_irq(20, c, vv);
        check(c == 3, "R12 reserved mode expiry", c, 3);
        count_irqs(20, c);
        check(c == 0, "R12 reserved mode acts one-shot", c, 0);
    endtask

    task automatic t_deadline();
        int c; logic [7:0] vv; logic [31:0] v;
        wr(3'd0, 32'h0000_0055);
        wr(3'd1, 32'd50);
        wr(3'd0, 32'h0004_0055);
        rd(3'd1, v);
        check(v == 0, "R7 start cleared on entry", v, 0);
        rd(3'd2, v);
        check(v == 0, "R7 count cleared on entry", v, 0);
        count_irqs(60, c);
        check(c == 0, "R7 old count gives no pulse", c, 0);
        wr(3'd1, 32'd9);
        rd(3'd1, v);
        check(v == 0, "R10 start ignored in deadline mode", v, 0);
        ts = 64'd100;
        wr(3'd5, 32'd0);
        wr(3'd4, 32'd200);
        count_irqs(10, c);
        check(c == 0, "R8 no pulse before deadline", c, 0);
        ts = 64'd200;
        wait_irq(5, c, vv);
        check(c == 1, "R8 pulse at deadline", c, 1);
        check(vv == 8'h55, "R8 deadline vector", vv, 8'h55);
        rd(3'd4, v);
        check(v == 0, "R8 deadline cleared", v, 0);
        count_irqs(10, c);
        check(c == 0, "R8 fires only once", c, 0);
        ts = 64'd1000;
        wr(3'd4, 32'd0);
        wr(3'd5, 32'd0);
        count_irqs(10, c);
        check(c == 0, "R9 zero deadline silent", c, 0);
        ts = 64'd0;
        wr(3'd4, 32'd300);
        wr(3'd0, 32'h0000_0055);
        rd(3'd4, v);
        check(v == 0, "R7 deadline cleared on exit", v, 0);
        ts = 64'd5000;
        count_irqs(20, c);
        check(c == 0, "R7 stale deadline gives no pulse", c, 0);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_oneshot();
        t_div();
        t_periodic();
        t_switch();
        t_clamp();
        t_divchange();
        t_mask_rsvd();
        t_deadline();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule